// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block decides which of a set of maskable peripheral interrupt sources is presented to the processor. Each source owns a small control register. The register holds a three-bit priority level and a pending-request flag. A peripheral event line sets the flag. Software writes the level, and it may clear the flag but can never set it.

Every cycle the block compares all pending sources against the processor's running priority level and its global interrupt enable. It then reports one winner: a valid strobe, the source number and that source's level. The acceptance sequencer pulses a clear strobe with a source number to retire the request it has taken.

The winner is computed combinationally from the registered control state and the current processor inputs. When several sources share the top level, the lowest-numbered one wins.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset every source's level and request flag are zero, and `irq_valid`, `irq_index` and `irq_level` are zero.
- R2: A control register reads as an 8-bit value with the level in bits 2..0, the request flag in bit 3 and zeros in bits 7..4. A software write loads bits 2..0 of `sw_wdata` into the level at the next clock edge.
- R3: A software write with `sw_wdata[3]` = 0 clears the addressed request flag. A write with `sw_wdata[3]` = 1 leaves the flag unchanged, so a clear flag stays clear.
- R4: A high `hw_set[i]` sets the request flag of source i at the next clock edge.
- R5: When `hw_set[i]` is high in the same cycle as a clear of source i, the flag ends up set. The clear may come from a software write or from `ack_clr`.
- R6: A pulse on `ack_clr` clears the request flag of source `ack_idx` and of no other source.
- R7: A source whose level is 0 is never reported, even when its flag is set.
- R8: A source qualifies only when three conditions hold together: its flag is 1, its level is strictly greater than `cpu_ipl`, and `cpu_ie` is 1.
- R9: Among qualifying sources, the one with the highest level is reported. When levels are equal, the lowest source number wins.
- R10: `irq_valid` is low when no source qualifies, and `irq_index` and `irq_level` are then zero. The outputs follow changes in `cpu_ipl`, `cpu_ie` and the registered state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | IDX_W | Source selected for software read and write |
| sw_wdata | input | 4 | Write data: bit 3 request flag, bits 2..0 level |
| sw_rdata | output | 8 | Read data of the selected control register |
| hw_set | input | NUM_SRC | Peripheral event lines, one per source |
| ack_clr | input | 1 | Clear strobe from the acceptance sequencer |
| ack_idx | input | IDX_W | Source cleared by `ack_clr` |
| cpu_ipl | input | 3 | Running processor priority level |
| cpu_ie | input | 1 | Global interrupt enable |
| irq_valid | output | 1 | A source qualifies |
| irq_index | output | IDX_W | Number of the winning source |
| irq_level | output | 3 | Level of the winning source |

## Verification
Two things can act on the same request flag in one cycle: a peripheral set, and a clear from either the software write path or the acceptance strobe. The bench drives both together on purpose, in directed steps and in the random mix where set lines, writes and clears land on overlapping sources. After each such cycle it reads the flag back through the register read port and watches the winner outputs. It expects the set to win.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int LVL_W = 3;

    typedef struct packed {
        logic             flag;
        logic [LVL_W-1:0] lvl;
    } src_ctl_t;

endpackage

// File: rtl/irq_src_ctl.sv
module irq_src_ctl
    import irq_res_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_sel,
    input  logic [3:0]     wdata,
    input  logic           hw_set,
    input  logic           ack_sel,
    output src_ctl_t       ctl_q
);

    typedef struct packed {
        src_ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic clr;
        st_d = st_q;
        clr  = (wr_sel && !wdata[3]) || ack_sel;
        if (wr_sel) begin
            st_d.ctl.lvl = wdata[LVL_W-1:0];
        end
        if (hw_set) begin
            st_d.ctl.flag = 1'b1;
        end else if (clr) begin
            st_d.ctl.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;

    // R4
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> ctl_q.flag);

    // R3
    sw_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[3] && !hw_set && !ctl_q.flag) |=> !ctl_q.flag);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_sel && !hw_set) |=> !ctl_q.flag);

    // R2
    lvl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (ctl_q.lvl == $past(wdata[LVL_W-1:0])));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_res_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  src_ctl_t [NUM_SRC-1:0] ctl,
    input  logic [LVL_W-1:0]       ipl,
    input  logic                   ie,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_lvl
);

    logic [NUM_SRC-1:0] elig;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = ie && ctl[i].flag && (ctl[i].lvl != '0) && (ctl[i].lvl > ipl);
        end
    end

    // Scan from the top so that an equal level at a lower index overrides.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_valid || ctl[i].lvl >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = ctl[i].lvl;
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_res_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr,
    input  logic [IDX_W-1:0]   sw_addr,
    input  logic [3:0]         sw_wdata,
    output logic [7:0]         sw_rdata,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic               ack_clr,
    input  logic [IDX_W-1:0]   ack_idx,
    input  logic [2:0]         cpu_ipl,
    input  logic               cpu_ie,
    output logic               irq_valid,
    output logic [IDX_W-1:0]   irq_index,
    output logic [2:0]         irq_level
);

    src_ctl_t [NUM_SRC-1:0] ctl_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_ctl i_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (sw_wr && (sw_addr == IDX_W'(g))),
            .wdata   (sw_wdata),
            .hw_set  (hw_set[g]),
            .ack_sel (ack_clr && (ack_idx == IDX_W'(g))),
            .ctl_q   (ctl_q[g])
        );
    end

    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sw_addr == IDX_W'(i)) begin
                sw_rdata = {4'b0000, ctl_q[i].flag, ctl_q[i].lvl};
            end
        end
    end

    irq_arbiter #(.NUM_SRC(NUM_SRC)) i_arb (
        .ctl       (ctl_q),
        .ipl       (cpu_ipl),
        .ie        (cpu_ie),
        .win_valid (irq_valid),
        .win_idx   (irq_index),
        .win_lvl   (irq_level)
    );

    // R8
    above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cpu_ie && (irq_level > cpu_ipl)));

    // R7
    lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level != 3'd0));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_index == '0 && irq_level == 3'd0));

    // R2
    rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rdata[7:4] == 4'b0000);

endmodule

// File: tb/test_irq_prio_resolver.sv
`timescale 1ns/1ps
module test_irq_prio_resolver;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_wr;
    logic [IW-1:0] sw_addr;
    logic [3:0]    sw_wdata;
    logic [7:0]    sw_rdata;
    logic [N-1:0]  hw_set;
    logic          ack_clr;
    logic [IW-1:0] ack_idx;
    logic [2:0]    cpu_ipl;
    logic          cpu_ie;
    logic          irq_valid;
    logic [IW-1:0] irq_index;
    logic [2:0]    irq_level;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [2:0] m_lvl  [N];
    logic       m_flag [N];

    always #4 clk = ~clk;

    irq_prio_resolver #(.NUM_SRC(N)) i_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .hw_set(hw_set),
        .ack_clr(ack_clr), .ack_idx(ack_idx), .cpu_ipl(cpu_ipl),
        .cpu_ie(cpu_ie), .irq_valid(irq_valid), .irq_index(irq_index),
        .irq_level(irq_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner packed as {valid, index, level}.
    function automatic int exp_win(input logic [2:0] ipl, input logic ie);
        int v = 0;
        int bi = 0;
        int bl = 0;
        for (int i = 0; i < N; i++) begin
            if (ie && m_flag[i] && m_lvl[i] != 0 && m_lvl[i] > ipl && (v == 0 || m_lvl[i] > bl)) begin
                v = 1; bi = i; bl = m_lvl[i];
            end
        end
        return (v << 8) | (bi << 4) | bl;
    endfunction

    task automatic step(input string tag, input logic wr, input int addr, input logic [3:0] wd,
                        input logic [N-1:0] set, input logic ac, input int ai,
                        input logic [2:0] ipl, input logic ie);
        int w;
        sw_wr = wr; sw_addr = IW'(addr); sw_wdata = wd; hw_set = set;
        ack_clr = ac; ack_idx = IW'(ai); cpu_ipl = ipl; cpu_ie = ie;
        #1;
        w = exp_win(ipl, ie);
        chk({tag, " R10 valid"}, int'(irq_valid), (w >> 8) & 1);
        chk({tag, " R9 index"},  int'(irq_index), (w >> 4) & 15);
        chk({tag, " R8 level"},  int'(irq_level), w & 15);
        chk({tag, " R2 rdata"},  int'(sw_rdata), (int'(m_flag[addr]) << 3) | int'(m_lvl[addr]));
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            logic clr;
            clr = (wr && addr == i && !wd[3]) || (ac && ai == i);
            if (wr && addr == i) m_lvl[i] = wd[2:0];
            if (set[i]) m_flag[i] = 1'b1;
            else if (clr) m_flag[i] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int addr, input logic [2:0] ipl, input logic ie);
        step(tag, 1'b0, addr, 4'h0, '0, 1'b0, 0, ipl, ie);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_flag[i] = 0; end
        rst_n = 1'b0; sw_wr = 0; sw_addr = 0; sw_wdata = 0; hw_set = 0;
        ack_clr = 0; ack_idx = 0; cpu_ipl = 0; cpu_ie = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < N; i++) begin
            sw_addr = IW'(i); #1;
            chk("R1 reset rdata", int'(sw_rdata), 0);
        end
        chk("R1 reset valid", int'(irq_valid), 0);
        chk("R1 reset index", int'(irq_index), 0);
        chk("R1 reset level", int'(irq_level), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: write level 5 with flag bit 1 must not set the flag
        step("R3 wr1", 1'b1, 2, 4'hD, '0, 0, 0, 3'd4, 1'b1);
        idle("R3 after", 2, 3'd4, 1'b1);
        chk("R3 flag stays clear", int'(sw_rdata[3]), 0);
        chk("R2 level readback", int'(sw_rdata[2:0]), 5);
        // R4/R8: hardware set then qualify above ipl 4
        step("R4 set", 1'b0, 2, 4'h0, 8'h04, 0, 0, 3'd4, 1'b1);
        idle("R8 above", 2, 3'd4, 1'b1);
        chk("R8 src2 wins", int'(irq_index), 2);
        idle("R8 equal ipl", 2, 3'd5, 1'b1);
        chk("R8 strict compare", int'(irq_valid), 0);
        idle("R8 ie low", 2, 3'd0, 1'b0);
        chk("R8 ie gates", int'(irq_valid), 0);
        // R9: tie at level 5 with src6, then level 7 on src1
        step("R9 w6", 1'b1, 6, 4'h5, 8'h40, 0, 0, 3'd0, 1'b1);
        idle("R9 tie", 6, 3'd0, 1'b1);
        chk("R9 tie lowest index", int'(irq_index), 2);
        step("R9 w1", 1'b1, 1, 4'h7, 8'h02, 0, 0, 3'd0, 1'b1);
        idle("R9 high", 1, 3'd0, 1'b1);
        chk("R9 highest level", int'(irq_level), 7);
        // R7: level-0 source with flag set
        step("R7 set0", 1'b0, 0, 4'h0, 8'h01, 0, 0, 3'd0, 1'b1);
        step("R7 clr others", 1'b0, 0, 4'h0, '0, 1, 1, 3'd0, 1'b1);
        step("R7 clr2", 1'b1, 2, 4'h5, '0, 1, 6, 3'd0, 1'b1);
        idle("R7 only lvl0", 0, 3'd0, 1'b1);
        chk("R7 flag set at lvl0", int'(sw_rdata[3]), 1);
        chk("R7 not reported", int'(irq_valid), 0);
        // R5: set coincides with ack clear and with software clear
        step("R5 ack", 1'b0, 3, 4'h0, 8'h08, 1, 3, 3'd0, 1'b1);
        idle("R5 ack after", 3, 3'd0, 1'b1);
        chk("R5 set beats ack clear", int'(sw_rdata[3]), 1);
        step("R5 sw", 1'b1, 3, 4'h6, 8'h08, 0, 0, 3'd0, 1'b1);
        idle("R5 sw after", 3, 3'd0, 1'b1);
        chk("R5 set beats sw clear", int'(sw_rdata[3]), 1);
        // R6: ack clears only its own source
        step("R6 set4", 1'b0, 4, 4'h0, 8'h10, 0, 0, 3'd0, 1'b1);
        step("R6 ack3", 1'b0, 4, 4'h0, '0, 1, 3, 3'd0, 1'b1);
        idle("R6 after", 4, 3'd0, 1'b1);
        chk("R6 neighbour kept", int'(sw_rdata[3]), 1);
        idle("R6 src3", 3, 3'd0, 1'b1);
        chk("R6 target cleared", int'(sw_rdata[3]), 0);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic          wr = ($urandom % 10) < 3;
            logic [N-1:0]  st = '0;
            if (($urandom % 4) == 0) st = N'($urandom) & N'($urandom);
            step("RND", wr, int'($urandom % N), 4'($urandom), st,
                 ($urandom % 5) == 0, int'($urandom % N), 3'($urandom % 8),
                 ($urandom % 10) != 0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule